// File: doc/BRIEF.md
# Single-Error Hamming ECC Engine for Flash Data Chunks

This block computes a 24-bit parity code over a chunk of 512 bytes while the bytes stream past on a byte-wide input. It keeps one accumulator lane for each of several chip selects. A byte stream tagged with a chip select feeds only that lane. Each lane collects bytes only after its own restart pulse. It stops after a full chunk.

The code has two 12-bit halves. Take a 12-bit bit address made of the byte index (upper 9 bits) and the bit index within the byte (lower 3 bits). The upper half holds, for each address bit, the parity of every set data bit whose address has that bit at one. The lower half holds the same parity for every set data bit whose address has that bit at zero. The code leaves the block inverted, so an erased chunk of all 0xFF bytes gives an all-ones code.

Reading a lane returns its code and clears the lane. A read can also compare the code against a stored code and report the outcome: clean, a single flipped data bit (with its byte address and bit index), a flip in the stored code only, or uncorrectable. The block does not apply any correction to memory; it only reports where the error is.

Top module: `hecc_engine`

## Requirements
- R1: While reset is held and after it is released, `code_vld_o` and `res_vld_o` are low. Every lane is idle, so bytes sent to it are ignored and a read returns 24'hFFFFFF.
- R2: A pulse on `start_i[c]` clears lane c and makes it collect bytes starting from byte index 0. When a start arrives in the same cycle as a byte or a read for that lane, the start wins: the byte is dropped and the read does not clear the lane.
- R3: A byte d at index b contributes one term for each set bit k. The term uses the address a = {b, k} (12 bits). For every address bit j, upper bit j toggles if a[j] is 1; otherwise lower bit j toggles. `code_o` = ~{upper, lower}. `code_o[7:0]` is the first byte to store, then `[15:8]`, then `[23:16]`.
- R4: `code_vld_o` is high in exactly the cycle after a cycle with `rd_i` high.
- R5: A read of lane `rd_cs_i` clears that lane and makes it idle until its next start.
- R6: Lanes are independent of each other. An active lane ignores any byte after its 512th byte.
- R7: A chunk of 512 bytes of 0xFF gives the code 24'hFFFFFF. Checking it against a stored 24'hFFFFFF reports clean.
- R8: `res_vld_o` is high in the cycle after a read with `rd_chk_i` high, and only then. `res_kind_o` is computed from diff = computed code XOR `stored_i`, with the encoding 0 = clean, 1 = data bit, 2 = code bit, 3 = uncorrectable.
- R9: Suppose diff is nonzero and the low 12 bits of (diff XOR diff>>12) are all ones, with byte address diff[23:15] below 512. Then the kind is 1, `res_byte_o` = diff[23:15] and `res_bit_o` = diff[14:12].
- R10: A diff with exactly one bit set reports kind 2.
- R11: Any other nonzero diff reports kind 3. For every kind except 1, `res_byte_o` and `res_bit_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | NCS | Restart pulse, one bit per lane |
| dat_vld_i | input | 1 | Byte strobe |
| dat_cs_i | input | CSW | Lane that the byte belongs to |
| dat_i | input | 8 | Data byte |
| rd_i | input | 1 | Read and clear a lane |
| rd_cs_i | input | CSW | Lane to read |
| rd_chk_i | input | 1 | Also compare against `stored_i` |
| stored_i | input | CODE_W | Code stored with the data |
| code_vld_o | output | 1 | Code output valid |
| code_o | output | CODE_W | Inverted code of the lane that was read |
| res_vld_o | output | 1 | Check result valid |
| res_kind_o | output | 2 | Outcome code |
| res_byte_o | output | AW | Byte address of the flipped data bit |
| res_bit_o | output | 3 | Bit index of the flipped data bit |

## Verification
The assertions check on every cycle:
- the one-cycle timing of `code_vld_o` and `res_vld_o` relative to reads;
- that a zero diff is reported as clean and a one-hot diff as a code-bit error;
- that a data-bit outcome names the location held in the upper half of diff;
- that other outcomes carry a zero location.

Only the bench scenarios can show that the accumulated code matches the parity definition over whole chunks. The same holds for:
- lane independence;
- start priority;
- clearing on read;
- ignoring bytes beyond a chunk or sent to an idle lane;
- locating a real flipped bit in streamed data.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  typedef enum logic [1:0] {
    HC_CLEAN  = 2'd0,
    HC_DATA   = 2'd1,
    HC_CODE   = 2'd2,
    HC_UNCORR = 2'd3
  } hc_kind_e;
endpackage

// File: rtl/hecc_lane.sv
module hecc_lane #(
  parameter int CHUNK_BYTES = 512,
  localparam int AW     = $clog2(CHUNK_BYTES),
  localparam int HALF   = AW + 3,
  localparam int CODE_W = 2 * HALF,
  localparam int CW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              clr_i,
  input  logic              byte_en_i,
  input  logic [7:0]        byte_i,
  output logic [CODE_W-1:0] par_o
);
  logic [CODE_W-1:0] par_q, par_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              act_q, act_d;
  logic [HALF-1:0]   hi_c, lo_c, addr_v, mask_v;
  logic              take;

  // parity contribution of one byte at the current index
  always_comb begin
    hi_c   = '0;
    lo_c   = '0;
    addr_v = '0;
    mask_v = '0;
    for (int k = 0; k < 8; k++) begin
      addr_v = {cnt_q[AW-1:0], 3'(k)};
      mask_v = {HALF{byte_i[k]}};
      hi_c   = hi_c ^ (addr_v & mask_v);
      lo_c   = lo_c ^ (~addr_v & mask_v);
    end
  end

  assign take = byte_en_i && act_q && (cnt_q < CW'(CHUNK_BYTES));

  always_comb begin
    par_d = par_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (start_i) begin
      par_d = '0;
      cnt_d = '0;
      act_d = 1'b1;
    end else if (clr_i) begin
      par_d = '0;
      cnt_d = '0;
      act_d = 1'b0;
    end else if (take) begin
      par_d = par_q ^ {hi_c, lo_c};
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      par_q <= par_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign par_o = par_q;
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify #(
  parameter int CHUNK_BYTES = 512,
  localparam int AW     = $clog2(CHUNK_BYTES),
  localparam int HALF   = AW + 3,
  localparam int CODE_W = 2 * HALF
) (
  input  logic [CODE_W-1:0] calc_i,
  input  logic [CODE_W-1:0] stored_i,
  output logic [1:0]        kind_o,
  output logic [AW-1:0]     byte_o,
  output logic [2:0]        bit_o
);
  import hecc_pkg::*;

  logic [CODE_W-1:0] diff;
  logic [HALF-1:0]   fold;
  logic [AW-1:0]     loc_byte;
  logic              single;

  assign diff     = calc_i ^ stored_i;
  assign fold     = diff[HALF-1:0] ^ diff[CODE_W-1:HALF];
  assign loc_byte = diff[CODE_W-1:HALF+3];
  assign single   = (diff & (diff - CODE_W'(1))) == '0;

  always_comb begin
    kind_o = HC_UNCORR;
    byte_o = '0;
    bit_o  = '0;
    if (diff == '0) begin
      kind_o = HC_CLEAN;
    end else if (&fold) begin
      if (32'(loc_byte) < CHUNK_BYTES) begin
        kind_o = HC_DATA;
        byte_o = loc_byte;
        bit_o  = diff[HALF+2:HALF];
      end
    end else if (single) begin
      kind_o = HC_CODE;
    end
  end
endmodule

// File: rtl/hecc_engine.sv
module hecc_engine #(
  parameter int NCS         = 4,
  parameter int CHUNK_BYTES = 512,
  localparam int CSW    = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int AW     = $clog2(CHUNK_BYTES),
  localparam int CODE_W = 2 * (AW + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCS-1:0]    start_i,
  input  logic              dat_vld_i,
  input  logic [CSW-1:0]    dat_cs_i,
  input  logic [7:0]        dat_i,
  input  logic              rd_i,
  input  logic [CSW-1:0]    rd_cs_i,
  input  logic              rd_chk_i,
  input  logic [CODE_W-1:0] stored_i,
  output logic              code_vld_o,
  output logic [CODE_W-1:0] code_o,
  output logic              res_vld_o,
  output logic [1:0]        res_kind_o,
  output logic [AW-1:0]     res_byte_o,
  output logic [2:0]        res_bit_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CODE_W-1:0] lane_par [NCS];

  for (genvar c = 0; c < NCS; c++) begin : g_lane
    hecc_lane #(.CHUNK_BYTES(CHUNK_BYTES)) u_lane (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .start_i  (start_i[c]),
      .clr_i    (rd_i && (rd_cs_i == CSW'(c))),
      .byte_en_i(dat_vld_i && (dat_cs_i == CSW'(c))),
      .byte_i   (dat_i),
      .par_o    (lane_par[c])
    );
  end

  logic [CODE_W-1:0] calc;
  logic [1:0]        kind_c;
  logic [AW-1:0]     byte_c;
  logic [2:0]        bit_c;

  assign calc = ~lane_par[rd_cs_i];

  hecc_classify #(.CHUNK_BYTES(CHUNK_BYTES)) u_cls (
    .calc_i  (calc),
    .stored_i(stored_i),
    .kind_o  (kind_c),
    .byte_o  (byte_c),
    .bit_o   (bit_c)
  );

  logic              code_vld_d, res_vld_d, code_en, res_en;
  logic [CODE_W-1:0] code_d;
  logic [1:0]        kind_d;
  logic [AW-1:0]     byte_d;
  logic [2:0]        bit_d;

  always_comb begin
    code_en    = rd_i;
    res_en     = rd_i && rd_chk_i;
    code_vld_d = code_en;
    res_vld_d  = res_en;
    code_d     = code_en ? calc   : code_o;
    kind_d     = res_en  ? kind_c : res_kind_o;
    byte_d     = res_en  ? byte_c : res_byte_o;
    bit_d      = res_en  ? bit_c  : res_bit_o;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      code_vld_o <= 1'b0;
      res_vld_o  <= 1'b0;
      code_o     <= '0;
      res_kind_o <= '0;
      res_byte_o <= '0;
      res_bit_o  <= '0;
    end else begin
      code_vld_o <= code_vld_d;
      res_vld_o  <= res_vld_d;
      code_o     <= code_d;
      res_kind_o <= kind_d;
      res_byte_o <= byte_d;
      res_bit_o  <= bit_d;
    end
  end
endmodule

// File: rtl/hecc_engine_chk.sv
module hecc_engine_chk #(
  parameter int NCS         = 4,
  parameter int CHUNK_BYTES = 512,
  localparam int AW     = $clog2(CHUNK_BYTES),
  localparam int HALF   = AW + 3,
  localparam int CODE_W = 2 * HALF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_i,
  input logic              rd_chk_i,
  input logic [CODE_W-1:0] stored_i,
  input logic              code_vld_o,
  input logic [CODE_W-1:0] code_o,
  input logic              res_vld_o,
  input logic [1:0]        res_kind_o,
  input logic [AW-1:0]     res_byte_o,
  input logic [2:0]        res_bit_o
);
  logic [CODE_W-1:0] stored_q;
  logic [CODE_W-1:0] diff_w;
  always_ff @(posedge clk) stored_q <= stored_i;
  assign diff_w = code_o ^ stored_q;

  // R4
  rd_to_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> code_vld_o);
  // R4
  no_stray_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> !code_vld_o);
  // R8
  chk_to_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && rd_chk_i) |=> res_vld_o);
  // R8
  no_stray_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i && rd_chk_i) |=> !res_vld_o);
  // R8
  clean_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && diff_w == '0) |-> res_kind_o == 2'd0);
  // R9
  data_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && res_kind_o == 2'd1) |-> {res_byte_o, res_bit_o} == diff_w[CODE_W-1:HALF]);
  // R10
  code_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && $countones(diff_w) == 1) |-> res_kind_o == 2'd2);
  // R11
  loc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && res_kind_o != 2'd1) |-> (res_byte_o == '0 && res_bit_o == '0));
endmodule

bind hecc_engine hecc_engine_chk #(.NCS(NCS), .CHUNK_BYTES(CHUNK_BYTES)) u_chk (.*);

// File: tb/test_hecc_engine.sv
module test_hecc_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  start_i = '0;
  logic        dat_vld_i = 1'b0;
  logic [1:0]  dat_cs_i = '0;
  logic [7:0]  dat_i = '0;
  logic        rd_i = 1'b0;
  logic [1:0]  rd_cs_i = '0;
  logic        rd_chk_i = 1'b0;
  logic [23:0] stored_i = '0;
  logic        code_vld_o, res_vld_o;
  logic [23:0] code_o;
  logic [1:0]  res_kind_o;
  logic [8:0]  res_byte_o;
  logic [2:0]  res_bit_o;

  always #4 clk = ~clk;

  hecc_engine i_hecc_engine (.*);

  int nchk = 0, nfail = 0;
  bit reported = 0;

  typedef struct packed {
    logic [1:0]  pat;
    logic [7:0]  seed;
    logic [23:0] err;
    logic [1:0]  kind;
    logic [8:0]  byt;
    logic [2:0]  bt;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'd0, 8'h00, 24'h000000, 2'd0, 9'd0,   3'd0},
    '{2'd1, 8'h5A, 24'h000000, 2'd0, 9'd0,   3'd0},
    '{2'd2, 8'hC3, 24'h12DED2, 2'd1, 9'd37,  3'd5},
    '{2'd1, 8'h11, 24'hFFF000, 2'd1, 9'd511, 3'd7},
    '{2'd0, 8'h00, 24'h000FFF, 2'd1, 9'd0,   3'd0},
    '{2'd2, 8'h3C, 24'h000001, 2'd2, 9'd0,   3'd0},
    '{2'd1, 8'h77, 24'h800000, 2'd2, 9'd0,   3'd0},
    '{2'd1, 8'h09, 24'h000003, 2'd3, 9'd0,   3'd0},
    '{2'd0, 8'h00, 24'h12DED3, 2'd3, 9'd0,   3'd0}
  };

  function automatic logic [7:0] gen(int pat, int seed, int i);
    case (pat)
      0:       return 8'hFF;
      1:       return 8'(i * 31 + seed);
      2:       return 8'(i >> 1) ^ 8'(seed);
      default: return 8'(seed);
    endcase
  endfunction

  function automatic logic [7:0] byte_at(int pat, int seed, int i, int flip);
    logic [7:0] d = gen(pat, seed, i);
    if (flip >= 0 && i == flip / 8) d = d ^ 8'(1 << (flip % 8));
    return d;
  endfunction

  // model of the parity definition (R3)
  function automatic logic [23:0] ref_code(int pat, int seed, int len, int flip);
    logic [11:0] hi = '0, lo = '0, a;
    for (int i = 0; i < len; i++) begin
      logic [7:0] d = byte_at(pat, seed, i, flip);
      for (int k = 0; k < 8; k++) begin
        if (d[k]) begin
          a  = 12'(i * 8 + k);
          hi = hi ^ a;
          lo = lo ^ ~a;
        end
      end
    end
    return ~{hi, lo};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    end
    $finish;
  endtask

  task automatic quiet;
    start_i = '0; dat_vld_i = 0; rd_i = 0; rd_chk_i = 0;
  endtask

  task automatic do_start(int cs);
    @(negedge clk); quiet(); start_i[cs] = 1'b1;
  endtask

  task automatic put(int cs, logic [7:0] d);
    @(negedge clk); quiet(); dat_vld_i = 1; dat_cs_i = 2'(cs); dat_i = d;
  endtask

  task automatic stream(int cs, int pat, int seed, int len, int flip);
    for (int i = 0; i < len; i++) put(cs, byte_at(pat, seed, i, flip));
  endtask

  task automatic do_read(int cs, bit chk, logic [23:0] st);
    @(negedge clk); quiet(); rd_i = 1; rd_cs_i = 2'(cs); rd_chk_i = chk; stored_i = st;
    @(negedge clk); quiet();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [23:0] exp_c;
    repeat (3) @(negedge clk);
    check("R1 code_vld in reset", 32'(code_vld_o), 0);
    check("R1 res_vld in reset", 32'(res_vld_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 code_vld after reset", 32'(code_vld_o), 0);

    // R1: idle lane ignores bytes
    stream(1, 1, 8'h21, 4, -1);
    do_read(1, 0, 24'h0);
    check("R1 idle lane code", 32'(code_o), 32'hFFFFFF);
    check("R4 code_vld after read", 32'(code_vld_o), 1);
    check("R8 res_vld without check", 32'(res_vld_o), 0);

    // vector table
    foreach (VEC[v]) begin
      exp_c = ref_code(VEC[v].pat, VEC[v].seed, 512, -1);
      do_start(0);
      stream(0, VEC[v].pat, VEC[v].seed, 512, -1);
      do_read(0, 1, exp_c ^ VEC[v].err);
      check($sformatf("R3 code vec%0d", v), 32'(code_o), 32'(exp_c));
      check($sformatf("R8 kind vec%0d", v), 32'(res_kind_o), 32'(VEC[v].kind));
      check($sformatf("R9 R11 byte vec%0d", v), 32'(res_byte_o), 32'(VEC[v].byt));
      check($sformatf("R9 R11 bit vec%0d", v), 32'(res_bit_o), 32'(VEC[v].bt));
      check("R8 res_vld", 32'(res_vld_o), 1);
    end

    // R7: erased chunk
    do_start(0);
    stream(0, 0, 0, 512, -1);
    do_read(0, 1, 24'hFFFFFF);
    check("R7 erased code", 32'(code_o), 32'hFFFFFF);
    check("R7 erased clean", 32'(res_kind_o), 0);

    // R9: real flipped data bit, byte 100 bit 2
    do_start(2);
    stream(2, 1, 8'h42, 512, 802);
    do_read(2, 1, ref_code(1, 8'h42, 512, -1));
    check("R9 flipped kind", 32'(res_kind_o), 1);
    check("R9 flipped byte", 32'(res_byte_o), 100);
    check("R9 flipped bit", 32'(res_bit_o), 2);

    // R6: overflow bytes ignored, lanes independent
    do_start(2);
    do_start(3);
    stream(2, 2, 8'h5F, 512, -1);
    put(2, 8'hA5); put(2, 8'h3C); put(2, 8'h81);
    stream(3, 1, 8'h13, 5, -1);
    do_read(2, 0, 24'h0);
    check("R6 overflow ignored", 32'(code_o), 32'(ref_code(2, 8'h5F, 512, -1)));
    do_read(3, 0, 24'h0);
    check("R6 lane independence", 32'(code_o), 32'(ref_code(1, 8'h13, 5, -1)));

    // R5: read clears and idles
    put(3, 8'hF0);
    do_read(3, 0, 24'h0);
    check("R5 cleared and idle", 32'(code_o), 32'hFFFFFF);

    // R2: start beats a same-cycle byte, and restarts mid-stream
    do_start(1);
    stream(1, 1, 8'h66, 10, -1);
    @(negedge clk); quiet(); start_i[1] = 1; dat_vld_i = 1; dat_cs_i = 2'd1; dat_i = 8'hFF;
    put(1, 8'h01);
    do_read(1, 0, 24'h0);
    check("R2 start priority", 32'(code_o), 32'hFFF000);

    // R2: start beats a same-cycle read
    do_start(1);
    put(1, 8'h01);
    @(negedge clk); quiet(); start_i[1] = 1; rd_i = 1; rd_cs_i = 2'd1;
    put(1, 8'h80);
    do_read(1, 0, 24'h0);
    check("R2 start over read", 32'(code_o), 32'(ref_code(3, 8'h80, 1, -1)));

    report();
  end
endmodule